// File: doc/BRIEF.md
# Pipelined Load/Store Unit for a 32-bit RISC-V Core

This block turns load and store operations from the execute stage of a 32-bit RISC-V pipeline into word-wide requests on a simple memory bus. It adds the base operand and the displacement to form the effective address. It drives the word address, a 4-bit byte-enable mask and lane-replicated store data onto the bus. When the memory answers, it extracts and sign- or zero-extends sub-word load data. It returns each result to the register file with a valid strobe, a write enable and the destination index that was issued with that request.

Several requests may be in flight at once, up to a limit set by a parameter (1 to 3). Responses arrive in issue order, one for each accepted request, loads and stores alike. A small tag queue holds the per-request decode information until the response arrives. A second parameter selects whether the formatted result leaves the unit straight from the bus response or one cycle later from a register. The memory may answer one or more cycles after accepting a request.

Top module: `lsu_core`

## Requirements
- R1: The effective address is the 32-bit sum of the base and the displacement, with wrap-around. The bus word address equals the effective address shifted right by two.
- R2: The byte enables depend on the store size. Byte accesses use 4'b0001 shifted left by the byte offset (address bits 1:0). Half-word accesses use 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. Word accesses use 4'b1111. The write strobe is high only for stores.
- R3: Store data places the low byte (SB, funct3 000) or the low half-word (SH, funct3 001) of the store operand into every enabled lane. SW (funct3 010) passes all 32 bits.
- R4: Byte loads use LB (funct3 000), which sign-extends, and LBU (funct3 100), which zero-extends, applied to the byte at the address offset. For the word 0x705a8000: LBU at offset 1 gives 0x80, LB at offset 1 gives 0xffffff80 and LB at offset 2 gives 0x5a.
- R5: Half-word loads use LH (funct3 001), which sign-extends, and LHU (funct3 101), which zero-extends, applied to the half selected by address bit 1. For the word 0x705a8000: LHU at offset 0 gives 0x8000, LH at offset 0 gives 0xffff8000 and LH at offset 2 gives 0x705a.
- R6: LW (funct3 010) returns the full word unchanged.
- R7: Every accepted request produces exactly one result with valid high, in issue order. Loads raise the write enable and return the destination index issued with them. Stores keep the write enable low.
- R8: No more than MAX_OUTSTANDING requests are ever in flight, counted from acceptance until their response. Busy is high while the limit is reached.
- R9: A request is accepted only on a cycle where request-enable is high and busy is low. Busy is high while a request is presented and the bus does not acknowledge it.
- R10: With REG_READ = 0 the result is valid in the same cycle as the bus response. With REG_READ = 1 it is valid exactly one cycle later.
- R11: During and right after reset, busy, result-valid and bus-request are low while no request is presented.
- R12: Results are correct when the memory answers one cycle after acceptance and when it answers two cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_en_i | input | 1 | Operation presented |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_funct3_i | input | 3 | RV32I funct3 of the operation |
| req_base_i | input | 32 | Base operand |
| req_disp_i | input | 32 | Sign-extended displacement |
| req_wdata_i | input | 32 | Store operand |
| req_rd_i | input | 5 | Destination register index |
| busy_o | output | 1 | Operation cannot be accepted this cycle |
| bus_req_o | output | 1 | Bus request strobe |
| bus_we_o | output | 1 | Bus write strobe |
| bus_adr_o | output | 30 | Bus word address |
| bus_sel_o | output | 4 | Byte enables |
| bus_wdata_o | output | 32 | Bus write data |
| bus_ack_i | input | 1 | Bus accepts the request this cycle |
| bus_rvalid_i | input | 1 | Response for the oldest outstanding request |
| bus_rdata_i | input | 32 | Response read data |
| res_valid_o | output | 1 | Access completed |
| res_we_o | output | 1 | Register file write enable |
| res_rd_o | output | 5 | Destination register index |
| res_data_o | output | 32 | Load result |

## Verification
The hardest situation to reach is a full tag queue that coincides with a refused acknowledge and a response in the same cycle. A response must then leave the queue while a new request waits and busy stays high. Long back-to-back bursts are issued against a memory with a two-cycle answer, while a pseudo-random generator withdraws the acknowledge, so that the queue repeatedly reaches its limit under stall. Every burst is then read back through loads of all sizes. A misplaced lane, a lost tag or an out-of-order result then shows up as a wrong value at the result port.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int XLEN    = 32;
    localparam int RD_W    = 5;
    localparam int LANES   = XLEN / 8;
    localparam int WADR_W  = XLEN - 2;

    // access size in funct3[1:0]
    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;

    typedef struct packed {
        logic            is_store;
        logic            zero_ext;
        logic [1:0]      size;
        logic [1:0]      offs;
        logic [RD_W-1:0] rd;
    } tag_t;

    typedef struct packed {
        logic            valid;
        logic            we;
        logic [RD_W-1:0] rd;
        logic [XLEN-1:0] data;
    } result_t;

    function automatic logic [LANES-1:0] lane_mask(logic [1:0] size, logic [1:0] offs);
        case (size)
            SZ_BYTE: return 4'b0001 << offs;
            SZ_HALF: return 4'b0011 << {offs[1], 1'b0};
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] lane_data(logic [1:0] size, logic [XLEN-1:0] w);
        case (size)
            SZ_BYTE: return {4{w[7:0]}};
            SZ_HALF: return {2{w[15:0]}};
            default: return w;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] extract(logic [1:0] size, logic zext,
                                                logic [1:0] offs, logic [XLEN-1:0] word);
        logic [XLEN-1:0] sh;
        sh = word >> {offs, 3'b000};
        case (size)
            SZ_BYTE: return zext ? {24'b0, sh[7:0]}  : {{24{sh[7]}}, sh[7:0]};
            SZ_HALF: return zext ? {16'b0, sh[15:0]} : {{16{sh[15]}}, sh[15:0]};
            default: return word;
        endcase
    endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_pkg::*;
(
    input  logic [XLEN-1:0]   base_i,
    input  logic [XLEN-1:0]   disp_i,
    input  logic [1:0]        size_i,
    input  logic [XLEN-1:0]   wdata_i,
    output logic [WADR_W-1:0] wadr_o,
    output logic [1:0]        offs_o,
    output logic [LANES-1:0]  sel_o,
    output logic [XLEN-1:0]   wdata_o
);
    logic [XLEN-1:0] ea;

    always_comb begin
        ea      = base_i + disp_i;
        wadr_o  = ea[XLEN-1:2];
        offs_o  = ea[1:0];
        sel_o   = lane_mask(size_i, ea[1:0]);
        wdata_o = lane_data(size_i, wdata_i);
    end
endmodule

// File: rtl/lsu_tag_fifo.sv
module lsu_tag_fifo
    import lsu_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic push_i,
    input  tag_t din_i,
    input  logic pop_i,
    output tag_t dout_o,
    output logic full_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    tag_t          slots [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          empty;

    assign empty  = (count == '0);
    assign full_o = (count == CW'(DEPTH));
    assign dout_o = slots[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_i) begin
                slots[wptr] <= din_i;
                wptr        <= (wptr == LAST) ? '0 : wptr + 1'b1;
            end
            if (pop_i)
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            if (push_i && !pop_i)
                count <= count + 1'b1;
            else if (!push_i && pop_i)
                count <= count - 1'b1;
        end
    end

    // R7
    resp_has_tag_chk: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> !empty);
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
    import lsu_pkg::*;
#(
    parameter bit REG_STAGE = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rvalid_i,
    input  logic [XLEN-1:0] rdata_i,
    input  tag_t            tag_i,
    output result_t         res_o
);
    result_t fmt;

    always_comb begin
        fmt.valid = rvalid_i;
        fmt.we    = rvalid_i && !tag_i.is_store;
        fmt.rd    = tag_i.rd;
        fmt.data  = extract(tag_i.size, tag_i.zero_ext, tag_i.offs, rdata_i);
    end

    generate
        if (REG_STAGE) begin : g_reg
            result_t q;
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= fmt;
            end
            assign res_o = q;

            // R10
            reg_delay_chk: assert property (@(posedge clk) disable iff (rst)
                res_o.valid |-> $past(rvalid_i));
        end else begin : g_comb
            assign res_o = fmt;
        end
    endgenerate

    // R7
    we_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        res_o.we |-> res_o.valid);
endmodule

// File: rtl/lsu_core.sv
module lsu_core
    import lsu_pkg::*;
#(
    parameter int MAX_OUTSTANDING = 2,
    parameter bit REG_READ        = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_en_i,
    input  logic              req_store_i,
    input  logic [2:0]        req_funct3_i,
    input  logic [XLEN-1:0]   req_base_i,
    input  logic [XLEN-1:0]   req_disp_i,
    input  logic [XLEN-1:0]   req_wdata_i,
    input  logic [RD_W-1:0]   req_rd_i,
    output logic              busy_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [WADR_W-1:0] bus_adr_o,
    output logic [LANES-1:0]  bus_sel_o,
    output logic [XLEN-1:0]   bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic              bus_rvalid_i,
    input  logic [XLEN-1:0]   bus_rdata_i,
    output logic              res_valid_o,
    output logic              res_we_o,
    output logic [RD_W-1:0]   res_rd_o,
    output logic [XLEN-1:0]   res_data_o
);
    logic       q_full, accept;
    logic [1:0] offs;
    tag_t       new_tag, head_tag;
    result_t    res;

    lsu_addr_gen u_agen (
        .base_i  (req_base_i),
        .disp_i  (req_disp_i),
        .size_i  (req_funct3_i[1:0]),
        .wdata_i (req_wdata_i),
        .wadr_o  (bus_adr_o),
        .offs_o  (offs),
        .sel_o   (bus_sel_o),
        .wdata_o (bus_wdata_o)
    );

    assign bus_req_o = req_en_i && !q_full;
    assign bus_we_o  = req_store_i;
    assign accept    = bus_req_o && bus_ack_i;
    assign busy_o    = q_full || (req_en_i && !bus_ack_i);

    always_comb begin
        new_tag.is_store = req_store_i;
        new_tag.zero_ext = req_funct3_i[2];
        new_tag.size     = req_funct3_i[1:0];
        new_tag.offs     = offs;
        new_tag.rd       = req_rd_i;
    end

    lsu_tag_fifo #(.DEPTH(MAX_OUTSTANDING)) u_tags (
        .clk    (clk),
        .rst    (rst),
        .push_i (accept),
        .din_i  (new_tag),
        .pop_i  (bus_rvalid_i),
        .dout_o (head_tag),
        .full_o (q_full)
    );

    lsu_load_align #(.REG_STAGE(REG_READ)) u_align (
        .clk      (clk),
        .rst      (rst),
        .rvalid_i (bus_rvalid_i),
        .rdata_i  (bus_rdata_i),
        .tag_i    (head_tag),
        .res_o    (res)
    );

    assign res_valid_o = res.valid;
    assign res_we_o    = res.we;
    assign res_rd_o    = res.rd;
    assign res_data_o  = res.data;

    // R8
    limit_busy_chk: assert property (@(posedge clk) disable iff (rst)
        q_full |-> busy_o);

    // R9
    stall_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req_o && !bus_ack_i) |-> busy_o);

    // R2
    sel_shape_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req_o |-> ($countones(bus_sel_o) == 1 || $countones(bus_sel_o) == 2
                       || $countones(bus_sel_o) == 4));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_en_i |-> !bus_req_o);
endmodule

// File: tb/lsu_core_bench.sv
`timescale 1ns/100ps
module lsu_core_bench;
    localparam int MAXO = 2;
    localparam bit REGR = 1'b1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_en_i = 1'b0, req_store_i = 1'b0;
    logic [2:0]  req_funct3_i = '0;
    logic [31:0] req_base_i = '0, req_disp_i = '0, req_wdata_i = '0;
    logic [4:0]  req_rd_i = '0;
    logic        busy_o, bus_req_o, bus_we_o;
    logic [29:0] bus_adr_o;
    logic [3:0]  bus_sel_o;
    logic [31:0] bus_wdata_o;
    logic        bus_ack_i = 1'b1, bus_rvalid_i = 1'b0;
    logic [31:0] bus_rdata_i = '0;
    logic        res_valid_o, res_we_o;
    logic [4:0]  res_rd_o;
    logic [31:0] res_data_o;

    always #2.5 clk = ~clk;

    lsu_core #(.MAX_OUTSTANDING(MAXO), .REG_READ(REGR)) u_lsu_core (.*);

    typedef struct { logic we; logic [4:0] rd; logic [31:0] data; string tag; } exp_res_t;
    typedef struct { logic we; logic [29:0] adr; logic [3:0] sel; logic [31:0] wd; } exp_bus_t;
    typedef struct { logic [31:0] data; int due; } resp_t;

    exp_res_t    res_q[$];
    exp_bus_t    bus_q[$];
    resp_t       resp_q[$];
    int          resp_time_q[$];
    logic [31:0] mem [64];
    logic [31:0] ref_mem [64];
    int          checks = 0, fails = 0, cyc = 0, lat = 1, outstanding = 0;
    bit          ack_rand = 1'b0, done = 1'b0;
    logic [15:0] lfsr = 16'hace1;

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_load(logic [2:0] f3, logic [31:0] w, logic [1:0] off);
        logic [7:0]  b;
        logic [15:0] h;
        b = w[off*8 +: 8];
        h = off[1] ? w[31:16] : w[15:0];
        case (f3)
            3'b000:  return {{24{b[7]}}, b};
            3'b100:  return {24'h0, b};
            3'b001:  return {{16{h[15]}}, h};
            3'b101:  return {16'h0, h};
            default: return w;
        endcase
    endfunction

    function automatic logic [31:0] byte_mask(logic [3:0] s);
        return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    endfunction

    // memory model, scoreboard monitor and bus checks
    always @(negedge clk) begin
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        bus_ack_i    = ack_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
        bus_rvalid_i = 1'b0;
        bus_rdata_i  = '0;
        if (!rst && resp_q.size() > 0 && resp_q[0].due <= cyc) begin
            bus_rvalid_i = 1'b1;
            bus_rdata_i  = resp_q[0].data;
            void'(resp_q.pop_front());
            resp_time_q.push_back(cyc);
            outstanding--;
        end
        #2;
        if (!rst) begin
            if (res_valid_o) begin
                if (res_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected result", {27'b0, res_rd_o}, 32'h0);
                end else begin
                    exp_res_t e;
                    int t;
                    e = res_q.pop_front();
                    t = (resp_time_q.size() > 0) ? resp_time_q.pop_front() : -100;
                    check(res_we_o == e.we, "R7", "write enable", {31'b0, res_we_o}, {31'b0, e.we});
                    if (e.we) begin
                        check(res_rd_o == e.rd, "R7", "dest index", {27'b0, res_rd_o}, {27'b0, e.rd});
                        check(res_data_o == e.data, e.tag, "load data", res_data_o, e.data);
                    end
                    check(cyc - t == int'(REGR), "R10", "result delay", cyc - t, REGR);
                end
            end
            if (bus_req_o && !bus_ack_i)
                check(busy_o, "R9", "busy under refused ack", {31'b0, busy_o}, 32'h1);
            if (bus_req_o && bus_ack_i) begin
                if (bus_q.size() == 0) begin
                    check(1'b0, "R9", "request without accept", 32'h1, 32'h0);
                end else begin
                    exp_bus_t b;
                    b = bus_q.pop_front();
                    check(bus_adr_o == b.adr, "R1", "word address", {2'b0, bus_adr_o}, {2'b0, b.adr});
                    check(bus_we_o == b.we, "R2", "write strobe", {31'b0, bus_we_o}, {31'b0, b.we});
                    if (b.we) begin
                        check(bus_sel_o == b.sel, "R2", "byte enables", {28'b0, bus_sel_o}, {28'b0, b.sel});
                        check((bus_wdata_o & byte_mask(b.sel)) == (b.wd & byte_mask(b.sel)),
                              "R3", "store lanes", bus_wdata_o, b.wd);
                    end
                end
                if (bus_we_o) begin
                    for (int i = 0; i < 4; i++)
                        if (bus_sel_o[i]) mem[bus_adr_o[5:0]][i*8 +: 8] = bus_wdata_o[i*8 +: 8];
                    resp_q.push_back('{32'h0, cyc + lat});
                end else begin
                    resp_q.push_back('{mem[bus_adr_o[5:0]], cyc + lat});
                end
                outstanding++;
                check(outstanding <= MAXO, "R8", "in-flight count", outstanding, MAXO);
            end
        end
    end

    task automatic issue(bit st, logic [2:0] f3, logic [31:0] base, logic [31:0] disp,
                         logic [31:0] wd, logic [4:0] rd, string tag);
        logic [31:0] ea;
        logic [1:0]  off;
        logic [5:0]  wi;
        exp_bus_t    b;
        exp_res_t    r;
        ea  = base + disp;
        off = ea[1:0];
        wi  = ea[7:2];
        @(negedge clk);
        req_en_i = 1'b1; req_store_i = st; req_funct3_i = f3;
        req_base_i = base; req_disp_i = disp; req_wdata_i = wd; req_rd_i = rd;
        #1;
        while (busy_o) begin
            @(negedge clk);
            #1;
        end
        b.we = st; b.adr = ea[31:2]; b.wd = 32'h0;
        case (f3[1:0])
            2'b00:   begin b.sel = 4'b0001 << off; b.wd[off*8 +: 8] = wd[7:0]; end
            2'b01:   begin b.sel = off[1] ? 4'b1100 : 4'b0011;
                           if (off[1]) b.wd[31:16] = wd[15:0]; else b.wd[15:0] = wd[15:0]; end
            default: begin b.sel = 4'b1111; b.wd = wd; end
        endcase
        bus_q.push_back(b);
        if (st) ref_mem[wi] = (ref_mem[wi] & ~byte_mask(b.sel)) | (b.wd & byte_mask(b.sel));
        r.we = !st; r.rd = rd; r.tag = tag;
        r.data = st ? 32'h0 : ref_load(f3, ref_mem[wi], off);
        res_q.push_back(r);
    endtask

    task automatic idle();
        @(negedge clk);
        req_en_i = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        idle();
        while ((res_q.size() != 0 || resp_q.size() != 0) && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        repeat (REGR + 2) @(negedge clk);
        check(res_q.size() == 0, "R12", "results pending after drain", res_q.size(), 0);
    endtask

    task automatic run_suite(int seed);
        logic [31:0] pat [8];
        for (int i = 0; i < 8; i++) pat[i] = 32'h1357_9bdf * (i + seed) ^ 32'h0f1e_2d3c;
        // burst of word stores then word loads
        for (int i = 0; i < 8; i++) issue(1'b1, 3'b010, 32'h0, i * 4, pat[i], 5'd1, "R6");
        for (int i = 0; i < 8; i++) issue(1'b0, 3'b010, 32'h0, i * 4, 32'h0, 5'(i + 2), "R6");
        // byte stores into words 5,6 and half stores into words 7,8
        for (int i = 0; i < 8; i++)
            issue(1'b1, 3'b000, 32'd20, i, pat[i / 4] >> ((i % 4) * 8), 5'd3, "R3");
        for (int i = 0; i < 8; i += 2)
            issue(1'b1, 3'b001, 32'd28, i, pat[i / 4] >> (((i / 2) % 2) * 16), 5'd3, "R3");
        for (int i = 5; i < 9; i++) issue(1'b0, 3'b010, 32'h0, i * 4, 32'h0, 5'(i + 10), "R3");
        // signed/unsigned sub-word loads; negative displacement reaches word 3
        issue(1'b1, 3'b010, 32'd16, 32'hffff_fffc, 32'h705a_8000, 5'd0, "R1");
        issue(1'b0, 3'b100, 32'd12, 32'd1, 32'h0, 5'd20, "R4");
        issue(1'b0, 3'b000, 32'd12, 32'd1, 32'h0, 5'd21, "R4");
        issue(1'b0, 3'b000, 32'd12, 32'd2, 32'h0, 5'd22, "R4");
        issue(1'b0, 3'b100, 32'd12, 32'd3, 32'h0, 5'd23, "R4");
        issue(1'b0, 3'b101, 32'd12, 32'd0, 32'h0, 5'd24, "R5");
        issue(1'b0, 3'b001, 32'd12, 32'd0, 32'h0, 5'd25, "R5");
        issue(1'b0, 3'b001, 32'd12, 32'd2, 32'h0, 5'd26, "R5");
        issue(1'b0, 3'b101, 32'd12, 32'd2, 32'h0, 5'd27, "R5");
        drain();
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin mem[i] = '0; ref_mem[i] = '0; end
        repeat (3) @(negedge clk);
        #1;
        // R11 reset state
        check(!busy_o, "R11", "busy in reset", {31'b0, busy_o}, 32'h0);
        check(!res_valid_o, "R11", "valid in reset", {31'b0, res_valid_o}, 32'h0);
        check(!bus_req_o, "R11", "bus request in reset", {31'b0, bus_req_o}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(!busy_o && !res_valid_o && !bus_req_o, "R11", "idle after reset",
              {29'b0, busy_o, res_valid_o, bus_req_o}, 32'h0);
        // fixed example word: direct literal checks of R4/R5 values via reference
        check(ref_load(3'b100, 32'h705a8000, 2'd1) == 32'h80, "R4", "ref LBU", 0, 32'h80);
        check(ref_load(3'b001, 32'h705a8000, 2'd2) == 32'h705a, "R5", "ref LH", 0, 32'h705a);
        for (int l = 1; l <= 2; l++) begin
            for (int a = 0; a < 2; a++) begin
                lat = l;          // R12: one and two cycle memory
                ack_rand = a[0];  // R9: refused acknowledges
                run_suite(l * 4 + a);
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #750000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule